// File: doc/BRIEF.md
# Alternating-Pattern RAM Self-Test Sequencer

This block runs a self-test over a byte-wide region of a synchronous single-port RAM. It is the RAM's master. The test has two passes. The upward pass starts at the region's lowest address, writes 0xAA to each byte and reads that byte straight back. The downward pass starts at the highest address, writes 0x55 to each byte and reads it back the same way. Every read is checked before the address moves on, so a fault is found at the location where it occurs.

The result goes out on two 8-bit codes that feed a dual DAC:

- While the test is running without error, both codes sit at 0x00.
- When a readback differs from what was written, the sequencer stops all RAM traffic. Both codes go to 0x7F and an error flag rises. This state is held until reset.
- When both passes finish cleanly, a one-cycle completion pulse is given and the upward pass starts again at once.

A start input launches the first run after reset.

Top module: `altpat_ramcheck`

## Requirements
- R1: After reset, and until start is seen high, the block issues no RAM write, and passDone and failed are low.
- R2: The upward pass writes 0xAA at BASE, then BASE+1 and so on up to BASE+MEM_BYTES-1. It spends three clock cycles per location: a write cycle, a read cycle and a compare cycle. The first write cycle is the clock cycle right after the edge that samples start.
- R3: In the cycle after each write, the block presents the same address with the write enable low. The read data returned one clock later is compared during the third cycle, and the address stays unchanged through all three cycles.
- R4: The downward pass follows the last upward location directly. It writes 0x55 at BASE+MEM_BYTES-1, then each lower address in turn, and ends after BASE has been written and checked.
- R5: A compare that fails in either pass raises failed and drives both DAC codes to 0x7F from the next cycle. From then until reset, failed stays high, both codes stay at 0x7F, and the write enable stays low.
- R6: After the downward pass checks BASE with no error, the upward pass restarts at BASE without any new start. passDone is high for exactly the one cycle of that restart's first write.
- R7: start has no effect once the test is running.
- R8: Both DAC codes read 0x00 whenever no failure is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches the test from idle |
| memAddr | output | ADDR_W | RAM address (BASE plus location offset) |
| memWdata | output | 8 | RAM write data (current pass pattern) |
| memWe | output | 1 | RAM write enable |
| memRdata | input | 8 | RAM read data, valid one clock after the address |
| dacA | output | 8 | DAC channel A code: 0x00 running, 0x7F on failure |
| dacB | output | 8 | DAC channel B code: 0x00 running, 0x7F on failure |
| passDone | output | 1 | One-cycle pulse when a full two-pass cycle ends cleanly |
| failed | output | 1 | High and held once a mismatch is latched |

## Verification
The bench builds the block with MEM_BYTES=8, ADDR_W=8 and BASE=0x40. With a region this small, a full two-pass cycle takes only 48 clocks, so every cycle of several back-to-back repetitions can be compared against an address and pattern sequence worked out in the bench.

The same small size allows a complete fault sweep. The bench RAM model forces one bit stuck at 0 or 1 at one location, and the sweep covers every location, every bit and both stuck values. Each fault is expected to trip either the upward or the downward pass, depending on that bit of the pattern. The sweep therefore reaches failures at the first and last address of both passes.

// File: rtl/altpat_pkg.sv
package altpat_pkg;

  localparam logic [7:0] PAT_UP    = 8'hAA;
  localparam logic [7:0] PAT_DOWN  = 8'h55;
  localparam logic [7:0] DAC_IDLE  = 8'h00;
  localparam logic [7:0] DAC_FAULT = 8'h7F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_CHECK,
    ST_HALT
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;      // begin a fresh test at the bottom, upward
    logic wrEn;       // drive a RAM write this cycle
    logic step;       // move to the next location in the current direction
    logic turn;       // reverse direction and jump to the far end
    logic latchFail;  // record a mismatch
  } strobe_t;

endpackage

// File: rtl/altpat_ctrl.sv
module altpat_ctrl
  import altpat_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    mismatch,
  input  logic    atEnd,
  output strobe_t strb
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.clear = 1'b1;
          stateNext  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strb.wrEn = 1'b1;
        stateNext = ST_READ;
      end
      ST_READ: begin
        stateNext = ST_CHECK;
      end
      ST_CHECK: begin
        if (mismatch) begin
          strb.latchFail = 1'b1;
          stateNext      = ST_HALT;
        end else begin
          if (atEnd) strb.turn = 1'b1;
          else       strb.step = 1'b1;
          stateNext = ST_WRITE;
        end
      end
      ST_HALT: begin
        stateNext = ST_HALT;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R5: once halted, only reset leaves
  p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_HALT |=> state == ST_HALT);

  // R3: every write is followed by its read cycle, then the compare
  p_write_then_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WRITE |=> state == ST_READ);

endmodule

// File: rtl/altpat_dpath.sv
module altpat_dpath
  import altpat_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 8192,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE      = 'hE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  output logic [7:0]        dacA,
  output logic [7:0]        dacB,
  output logic              passDone,
  output logic              failed,
  output logic              mismatch,
  output logic              atEnd
);

  localparam int unsigned OW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
  localparam logic [OW-1:0] LAST = OW'(MEM_BYTES - 1);

  logic [OW-1:0] offset;
  logic          goingDown;
  logic          failReg;
  logic          doneReg;
  logic [7:0]    dacCode;
  logic [7:0]    pattern;

  assign pattern  = goingDown ? PAT_DOWN : PAT_UP;
  assign mismatch = (memRdata != pattern);
  assign atEnd    = goingDown ? (offset == '0) : (offset == LAST);

  assign memAddr  = ADDR_W'(BASE) + ADDR_W'(offset);
  assign memWdata = pattern;
  assign memWe    = strb.wrEn;
  assign dacA     = dacCode;
  assign dacB     = dacCode;
  assign passDone = doneReg;
  assign failed   = failReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset    <= '0;
      goingDown <= 1'b0;
      failReg   <= 1'b0;
      doneReg   <= 1'b0;
      dacCode   <= DAC_IDLE;
    end else begin
      doneReg <= 1'b0;
      if (strb.clear) begin
        offset    <= '0;
        goingDown <= 1'b0;
        failReg   <= 1'b0;
        dacCode   <= DAC_IDLE;
      end
      if (strb.step) begin
        offset <= goingDown ? offset - 1'b1 : offset + 1'b1;
      end
      if (strb.turn) begin
        goingDown <= !goingDown;
        offset    <= goingDown ? '0 : LAST;
        doneReg   <= goingDown;
      end
      if (strb.latchFail) begin
        failReg <= 1'b1;
        dacCode <= DAC_FAULT;
      end
    end
  end

  // R5: failure indication is held and both channels sit at mid-scale
  p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    failed |=> failed && dacA == DAC_FAULT && dacB == DAC_FAULT);

  // R5: no RAM writes once a failure is latched
  p_no_write_after_fail_r5: assert property (@(posedge clk) disable iff (!rstN)
    failed |-> !memWe);

  // R3: the read cycle uses the address just written, with write low
  p_readback_same_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> $stable(memAddr) && !memWe);

  // R6: completion is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    passDone |=> !passDone);

  // R8: channels idle at zero while no failure is recorded
  p_dac_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !failed |-> dacA == DAC_IDLE && dacB == DAC_IDLE);

endmodule

// File: rtl/altpat_ramcheck.sv
module altpat_ramcheck
  import altpat_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 8192,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE      = 'hE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata,
  output logic [7:0]        dacA,
  output logic [7:0]        dacB,
  output logic              passDone,
  output logic              failed
);

  strobe_t strb;
  logic    mismatch;
  logic    atEnd;

  altpat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mismatch (mismatch),
    .atEnd    (atEnd),
    .strb     (strb)
  );

  altpat_dpath #(
    .MEM_BYTES (MEM_BYTES),
    .ADDR_W    (ADDR_W),
    .BASE      (BASE)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .dacA     (dacA),
    .dacB     (dacB),
    .passDone (passDone),
    .failed   (failed),
    .mismatch (mismatch),
    .atEnd    (atEnd)
  );

endmodule

// File: tb/tb_altpat_ramcheck.sv
module tb_altpat_ramcheck;

  localparam int N    = 8;
  localparam int AW   = 8;
  localparam int BASE = 'h40;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata;
  logic          memWe;
  logic [7:0]    memRdata;
  logic [7:0]    dacA, dacB;
  logic          passDone, failed;

  int vectors = 0;
  int misses  = 0;

  // Fault injection in the RAM model
  logic          faultOn;
  int            faultLoc;
  int            faultBit;
  logic          faultVal;
  logic [7:0]    ram [0:(1<<AW)-1];

  always #2.5 clk = ~clk;

  altpat_ramcheck #(.MEM_BYTES(N), .ADDR_W(AW), .BASE(BASE)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .dacA(dacA), .dacB(dacB), .passDone(passDone), .failed(failed)
  );

  always @(posedge clk) begin
    logic [7:0] rv;
    rv = ram[memAddr];
    if (faultOn && int'(memAddr) == BASE + faultLoc) rv[faultBit] = faultVal;
    memRdata <= rv;
    if (memWe) ram[memAddr] <= memWdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    start = 1'b0;
    rstN  = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset we", memWe, 0);
    chk("R1 reset done", passDone, 0);
    chk("R1 reset failed", failed, 0);
    chk("R8 reset dacA", dacA, 0);
    chk("R8 reset dacB", dacB, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 idle no write", memWe, 0);
    end
  endtask

  // reps full cycles expected; holdStart keeps start high (R7)
  task automatic runCase(input int reps, input logic holdStart);
    logic hit;
    start = 1'b1;
    @(negedge clk);
    if (!holdStart) start = 1'b0;
    for (int rep = 0; rep < reps; rep++) begin
      for (int pass = 0; pass < 2; pass++) begin
        for (int i = 0; i < N; i++) begin
          int loc;
          logic [7:0] pat;
          loc = (pass == 0) ? i : N - 1 - i;
          pat = (pass == 0) ? 8'hAA : 8'h55;
          // write cycle
          chk(pass == 0 ? "R2 write we" : "R4 write we", memWe, 1);
          chk(pass == 0 ? "R2 write addr" : "R4 write addr", memAddr, BASE + loc);
          chk(pass == 0 ? "R2 write data" : "R4 write data", memWdata, pat);
          chk("R6 done pulse", passDone, (rep > 0 && pass == 0 && i == 0) ? 1 : 0);
          chk("R8 dac running", {dacA, dacB}, 0);
          chk("R7 no stray fail", failed, 0);
          @(negedge clk);
          // read cycle
          chk("R3 read we low", memWe, 0);
          chk("R3 read addr", memAddr, BASE + loc);
          @(negedge clk);
          // compare cycle
          chk("R3 check we low", memWe, 0);
          chk("R3 check addr", memAddr, BASE + loc);
          chk("R6 no early done", passDone, 0);
          hit = faultOn && loc == faultLoc && pat[faultBit] != faultVal;
          @(negedge clk);
          if (hit) begin
            for (int k = 0; k < 6; k++) begin
              chk("R5 failed held", failed, 1);
              chk("R5 dacA 7F", dacA, 8'h7F);
              chk("R5 dacB 7F", dacB, 8'h7F);
              chk("R5 no write", memWe, 0);
              if (k == 2) start = 1'b1;
              @(negedge clk);
            end
            start = 1'b0;
            return;
          end
        end
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    faultOn = 1'b0; faultLoc = 0; faultBit = 0; faultVal = 1'b0;
    // fault-free run, start held high throughout (R7), three full cycles (R6)
    doReset();
    runCase(3, 1'b1);
    // single stuck bit at every location, bit and polarity (R5)
    for (int loc = 0; loc < N; loc++) begin
      for (int b = 0; b < 8; b++) begin
        for (int v = 0; v < 2; v++) begin
          faultOn = 1'b0;
          doReset();
          faultOn  = 1'b1;
          faultLoc = loc;
          faultBit = b;
          faultVal = v[0];
          runCase(1, 1'b0);
        end
      end
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule